// File: doc/BRIEF.md
# FM Synthesizer Dual Interval Timers

This block holds the pair of programmable interval timers that sit beside an FM sound generator. The fast timer advances once per base tick. The slow timer advances once per wrap of a free-running divide-by-16 prescaler, so it runs at one sixteenth of the base rate. Each timer counts up from a programmable reload value to overflow. On overflow it raises a sticky expiry flag, reloads itself and keeps running. Each flag can be masked before it reaches the shared interrupt line.

Software programs the block through a small write port: a 2-bit address, 8 bits of data and a write strobe. The tick enable marks the base ticks. The mode input selects between two behaviours. In legacy behaviour a timer starts with a full first period. In newer-generation behaviour counting begins on the control write itself, which removes one count from the first period. In that mode a first period of zero counts expires immediately.

Top module: `fm_dual_timer`

## Requirements
- R1: After reset both expiry flags and irq are 0 and both timers are stopped, so no flag rises however many ticks follow.
- R2: Address 0 holds bits 7:0 of the 10-bit fast reload value, and address 1 holds its bits 9:8 in data bits 1:0. Address 2 holds the 8-bit slow reload value. Address 3 is control: bit 0 runs the fast timer, bit 1 runs the slow timer, bit 2 masks the fast flag and bit 3 masks the slow flag (1 means masked). Bit 7 clears both flags.
- R3: In legacy mode (newMode=0), expA rises after the (1024 − v)-th tick following the control write that starts the fast timer, where v is the fast reload value.
- R4: The prescaler counts every tick since reset, modulo 16, and is never reset by a load. In legacy mode, expB rises after the (16·(256 − v) − p)-th tick following the start write, where p is the prescaler value at that write.
- R5: In newer-generation mode (newMode=1) the first periods are (1023 − v) for the fast timer and 16·(255 − v) − p for the slow timer. A first count of zero sets the flag at the start write itself, before any tick.
- R6: After every expiry the timer reloads with a full count: 1024 − v ticks for the fast timer and 256 − v prescaler wraps for the slow timer, in both modes.
- R7: A control write that keeps an already running timer's run bit set does not restart its count.
- R8: A control write that clears a run bit stops that timer, and it does not expire while stopped. A later start begins a fresh first period.
- R9: A reload register write during a count does not change the count in progress. It applies from the next load or auto-reload.
- R10: The flags are sticky until a control write with bit 7 set. Such a write clears both flags and leaves the run and mask bits unchanged.
- R11: irq is 1 exactly when an unmasked flag is set. A masked timer still sets its flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Base tick enable, one tick per cycle in which it is high |
| newMode | input | 1 | 1 selects newer-generation start behaviour |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address |
| wrData | input | 8 | Register write data |
| expA | output | 1 | Sticky fast timer expiry flag |
| expB | output | 1 | Sticky slow timer expiry flag |
| irq | output | 1 | Interrupt, OR of the unmasked flags |

## Verification
The assertions check on every cycle the properties that hold locally. A flag stays set until a clear write. A clear write empties both flags. irq never rises without a flag. A running fast timer only expires on a tick, and the slow timer only on a prescaler wrap. A stopped timer never expires. Legacy mode never expires on the start write. The exact period lengths cannot be seen in one cycle, so the bench's sweeps show them: the lengths across reload values and prescaler phases in both modes, the shortened first period and the immediate expiry, the no-restart rewrite, deferred reload writes, stop and restart, and masking.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  localparam logic [1:0] ADDR_A_LO = 2'd0;
  localparam logic [1:0] ADDR_A_HI = 2'd1;
  localparam logic [1:0] ADDR_B    = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  localparam int BIT_RUN_A  = 0;
  localparam int BIT_RUN_B  = 1;
  localparam int BIT_MASK_A = 2;
  localparam int BIT_MASK_B = 3;
  localparam int BIT_CLEAR  = 7;

  typedef struct packed {
    logic startA;
    logic startB;
    logic clrFlags;
  } fmtStrobes_t;
endpackage

// File: rtl/fmt_counter.sv
module fmt_counter #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] firstLen,
  input  logic [W-1:0] fullLen,
  output logic         hit
);
  logic [W-1:0] cnt;
  logic instant;
  logic wrapHit;

  always_comb begin
    instant = start && (firstLen == '0);
    wrapHit = run && !start && step && (cnt == W'(1));
    hit     = instant || wrapHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= instant ? fullLen : firstLen;
    end else if (run && step) begin
      cnt <= (cnt == W'(1)) ? fullLen : cnt - W'(1);
    end
  end
endmodule

// File: rtl/fmt_ctrl.sv
module fmt_ctrl
  import fmt_pkg::*;
#(
  parameter int A_BITS = 10,
  parameter int B_BITS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [7:0]        wrData,
  output fmtStrobes_t       stb,
  output logic              runA,
  output logic              runB,
  output logic              maskA,
  output logic              maskB,
  output logic [A_BITS-1:0] reloadA,
  output logic [B_BITS-1:0] reloadB
);
  localparam int A_HI = A_BITS - 8;

  logic ctrlWr;
  logic cfgWr;

  always_comb begin
    ctrlWr       = wrEn && (wrAddr == ADDR_CTRL);
    cfgWr        = ctrlWr && !wrData[BIT_CLEAR];
    stb.clrFlags = ctrlWr && wrData[BIT_CLEAR];
    stb.startA   = cfgWr && wrData[BIT_RUN_A] && !runA;
    stb.startB   = cfgWr && wrData[BIT_RUN_B] && !runB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runA    <= 1'b0;
      runB    <= 1'b0;
      maskA   <= 1'b0;
      maskB   <= 1'b0;
      reloadA <= '0;
      reloadB <= '0;
    end else begin
      if (cfgWr) begin
        runA  <= wrData[BIT_RUN_A];
        runB  <= wrData[BIT_RUN_B];
        maskA <= wrData[BIT_MASK_A];
        maskB <= wrData[BIT_MASK_B];
      end
      if (wrEn && wrAddr == ADDR_A_LO) reloadA[7:0] <= wrData;
      if (wrEn && wrAddr == ADDR_A_HI) reloadA[A_BITS-1:8] <= wrData[A_HI-1:0];
      if (wrEn && wrAddr == ADDR_B)    reloadB <= wrData[B_BITS-1:0];
    end
  end
endmodule

// File: rtl/fmt_datapath.sv
module fmt_datapath
  import fmt_pkg::*;
#(
  parameter int A_BITS   = 10,
  parameter int B_BITS   = 8,
  parameter int PRE_BITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                newMode,
  input  fmtStrobes_t         stb,
  input  logic                runA,
  input  logic                runB,
  input  logic [A_BITS-1:0]   reloadA,
  input  logic [B_BITS-1:0]   reloadB,
  output logic                flagA,
  output logic                flagB,
  output logic                hitA,
  output logic                hitB,
  output logic [PRE_BITS-1:0] preVal
);
  localparam int AW = A_BITS + 1;
  localparam int BW = B_BITS + 1;

  logic [AW-1:0] fullA, firstA;
  logic [BW-1:0] fullB, firstB;
  logic stepB;

  always_comb begin
    fullA  = AW'(1 << A_BITS) - AW'(reloadA);
    fullB  = BW'(1 << B_BITS) - BW'(reloadB);
    firstA = newMode ? fullA - AW'(1) : fullA;
    firstB = newMode ? fullB - BW'(1) : fullB;
    stepB  = tickEn && (preVal == '1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preVal <= '0;
    end else if (tickEn) begin
      preVal <= preVal + PRE_BITS'(1);
    end
  end

  fmt_counter #(.W(AW)) u_cntA (
    .clk(clk), .rstN(rstN), .start(stb.startA), .run(runA), .step(tickEn),
    .firstLen(firstA), .fullLen(fullA), .hit(hitA)
  );

  fmt_counter #(.W(BW)) u_cntB (
    .clk(clk), .rstN(rstN), .start(stb.startB), .run(runB), .step(stepB),
    .firstLen(firstB), .fullLen(fullB), .hit(hitB)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagA <= 1'b0;
      flagB <= 1'b0;
    end else begin
      flagA <= hitA || (flagA && !stb.clrFlags);
      flagB <= hitB || (flagB && !stb.clrFlags);
    end
  end
endmodule

// File: rtl/fm_dual_timer.sv
module fm_dual_timer
  import fmt_pkg::*;
#(
  parameter int A_BITS   = 10,
  parameter int B_BITS   = 8,
  parameter int PRE_BITS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       newMode,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  output logic       expA,
  output logic       expB,
  output logic       irq
);
  fmtStrobes_t         ctrlStb;
  logic                runA, runB, maskA, maskB;
  logic [A_BITS-1:0]   reloadA;
  logic [B_BITS-1:0]   reloadB;
  logic                hitA, hitB;
  logic [PRE_BITS-1:0] preVal;

  fmt_ctrl #(.A_BITS(A_BITS), .B_BITS(B_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stb(ctrlStb), .runA(runA), .runB(runB), .maskA(maskA), .maskB(maskB),
    .reloadA(reloadA), .reloadB(reloadB)
  );

  fmt_datapath #(.A_BITS(A_BITS), .B_BITS(B_BITS), .PRE_BITS(PRE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .newMode(newMode), .stb(ctrlStb),
    .runA(runA), .runB(runB), .reloadA(reloadA), .reloadB(reloadB),
    .flagA(expA), .flagB(expB), .hitA(hitA), .hitB(hitB), .preVal(preVal)
  );

  assign irq = (expA && !maskA) || (expB && !maskB);
endmodule

// File: rtl/fmt_checker.sv
module fmt_checker
  import fmt_pkg::*;
#(
  parameter int PRE_BITS = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                tickEn,
  input logic                newMode,
  input logic                wrEn,
  input logic [1:0]          wrAddr,
  input logic                clrBit,
  input logic                expA,
  input logic                expB,
  input logic                irq,
  input fmtStrobes_t         stb,
  input logic                runA,
  input logic                hitA,
  input logic                hitB,
  input logic [PRE_BITS-1:0] preVal
);
  logic clrWr;
  assign clrWr = wrEn && (wrAddr == ADDR_CTRL) && clrBit;

  AST_FLAG_STICKY_A: assert property (@(posedge clk) disable iff (!rstN)
    (expA && !clrWr) |=> expA); // R10
  AST_FLAG_STICKY_B: assert property (@(posedge clk) disable iff (!rstN)
    (expB && !clrWr) |=> expB); // R10
  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && !hitA && !hitB) |=> (!expA && !expB)); // R10
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (expA || expB)); // R11
  AST_A_HIT_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (hitA && !stb.startA) |-> tickEn); // R3
  AST_B_HIT_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (hitB && !stb.startB) |-> (tickEn && preVal == '1)); // R4
  AST_STOPPED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (!runA && !stb.startA) |-> !hitA); // R8
  AST_LEGACY_NO_INSTANT: assert property (@(posedge clk) disable iff (!rstN)
    !newMode |-> !((stb.startA && hitA) || (stb.startB && hitB))); // R5
  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (hitA || hitB) |=> (expA || expB)); // R6
endmodule

bind fm_dual_timer fmt_checker #(.PRE_BITS(PRE_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .newMode(newMode), .wrEn(wrEn),
  .wrAddr(wrAddr), .clrBit(wrData[7]), .expA(expA), .expB(expB), .irq(irq),
  .stb(ctrlStb), .runA(runA), .hitA(hitA), .hitB(hitB), .preVal(preVal)
);

// File: tb/fm_dual_timer_bench.sv
module fm_dual_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic newMode = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic expA, expB, irq;

  int errors = 0;
  int checks = 0;
  int totalTicks = 0;

  fm_dual_timer u_fm_dual_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .newMode(newMode), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .expA(expA), .expB(expB), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic tickN(input int n);
    tickEn = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      totalTicks++;
      @(negedge clk);
    end
    tickEn = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d; tickEn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic measure(input bit selB, input int limit, output int k);
    k = 0;
    while (((selB ? expB : expA) == 1'b0) && k < limit) begin
      tickN(1);
      k++;
    end
  endtask

  // R2 map: addr0/addr1 fast reload, addr2 slow reload, addr3 control
  task automatic setA(input int v);
    wr(2'd0, 8'(v & 255));
    wr(2'd1, 8'(v >> 8));
  endtask

  task automatic sweepA(input int v, input bit nm);
    int k;
    int exp;
    newMode = nm;
    setA(v);
    wr(2'd3, 8'h0D);                 // run A, both masked
    exp = nm ? 1023 - v : 1024 - v;
    measure(1'b0, 5000, k);
    check(nm ? "R5 fast first period" : "R3 fast first period", k, exp);
    check("R11 masked flag gives no irq", int'(irq), 0);
    wr(2'd3, 8'h80);                 // clear only
    check("R10 clear empties fast flag", int'(expA), 0);
    measure(1'b0, 5000, k);
    check("R6 fast reload period", k, 1024 - v);
    wr(2'd3, 8'h0C);
    wr(2'd3, 8'h80);
  endtask

  task automatic sweepB(input int v, input bit nm, input int idle);
    int k;
    int exp;
    int p;
    newMode = nm;
    tickN(idle);
    wr(2'd2, 8'(v));
    p = totalTicks % 16;
    wr(2'd3, 8'h0E);                 // run B, both masked
    if (nm) exp = (v == 255) ? 0 : 16 * (255 - v) - p;
    else    exp = 16 * (256 - v) - p;
    measure(1'b1, 9000, k);
    check(nm ? "R5 slow first period" : "R4 slow first period", k, exp);
    wr(2'd3, 8'h80);
    check("R10 clear empties slow flag", int'(expB), 0);
    p = totalTicks % 16;
    measure(1'b1, 9000, k);
    check("R6 slow reload period", k, 16 * (256 - v) - p);
    wr(2'd3, 8'h0C);
    wr(2'd3, 8'h80);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state and nothing runs
    check("R1 expA after reset", int'(expA), 0);
    check("R1 expB after reset", int'(expB), 0);
    check("R1 irq after reset", int'(irq), 0);
    tickN(5000);
    check("R1 no expiry while idle", int'(expA | expB | irq), 0);

    // R3 R5 R6: fast timer sweeps in both modes
    for (int m = 0; m < 2; m++) begin
      for (int v = 1000; v < 1024; v++) sweepA(v, bit'(m));
      sweepA(0, bit'(m));
      sweepA(512, bit'(m));
    end

    // R4 R5 R6: slow timer sweeps over reload values and prescaler phases
    for (int m = 0; m < 2; m++) begin
      for (int v = 250; v < 256; v++)
        for (int ph = 0; ph < 16; ph++) sweepB(v, bit'(m), ph + v);
      sweepB(0, bit'(m), 5);
    end

    newMode = 1'b0;
    // R7: rewriting the run bit keeps the count
    setA(923);
    wr(2'd3, 8'h0D);
    tickN(40);
    wr(2'd3, 8'h0D);
    measure(1'b0, 5000, k);
    check("R7 rewrite does not restart", k, 61);
    wr(2'd3, 8'h0C); wr(2'd3, 8'h80);

    // R9: reload write during a count is deferred
    setA(923);
    wr(2'd3, 8'h0D);
    tickN(30);
    setA(1000);
    measure(1'b0, 5000, k);
    check("R9 count in progress unchanged", k, 71);
    wr(2'd3, 8'h80);
    measure(1'b0, 5000, k);
    check("R9 new value at auto-reload", k, 24);
    wr(2'd3, 8'h0C); wr(2'd3, 8'h80);

    // R8: stop, no expiry, fresh restart
    wr(2'd3, 8'h0D);
    tickN(10);
    wr(2'd3, 8'h0C);
    tickN(200);
    check("R8 stopped timer silent", int'(expA), 0);
    wr(2'd3, 8'h0D);
    measure(1'b0, 5000, k);
    check("R8 restart gives fresh period", k, 24);
    wr(2'd3, 8'h0C); wr(2'd3, 8'h80);

    // R11 R10: masking and clear keeping mask
    setA(1020);
    wr(2'd3, 8'h01);                 // run A unmasked
    measure(1'b0, 5000, k);
    check("R11 unmasked flag raises irq", int'(irq), 1);
    wr(2'd3, 8'h05);                 // mask A, still running
    check("R11 mask drops irq", int'(irq), 0);
    check("R11 masked flag still set", int'(expA), 1);
    wr(2'd3, 8'h80);
    measure(1'b0, 5000, k);
    check("R10 clear kept run bit", k, 4);
    check("R10 clear kept mask bit", int'(irq), 0);
    wr(2'd3, 8'h00); wr(2'd3, 8'h80);
    check("R10 final clear", int'(expA | expB), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule